// File: doc/BRIEF.md
# Status-Source Interrupt Controller

This block gathers four event inputs from a secure-module host interface (data available, status valid, locality change and command ready) and turns them into one interrupt line. A rising edge on any event input latches a sticky pending bit. Pending bits stay set until software writes a 1 to them. Each source has its own enable bit, and one global enable bit gates the whole request.

Software reaches the block through a small register port: an enable register, an 8-bit vector register, a pending-status register and a read-only capability word. A 2-bit configuration input sets the shape of the line: an active-high level, an active-low level, a one-cycle high pulse or a one-cycle low pulse. An output state machine shapes the line. Its states are QUIET (line idle), LEVEL (request held in a level mode), PULSE (the single active cycle in an edge mode) and HOLD (an edge mode, request still high after the pulse). It has these transitions:
- QUIET to LEVEL or PULSE when the request is seen.
- PULSE to HOLD, or back to QUIET if the request has dropped.
- HOLD to LEVEL when the mode switches to a level mode.
- LEVEL to HOLD when the mode switches to an edge mode.
- Any state back to QUIET when the request is low.

Top module: `sic_irq_ctrl`

## Requirements
- R1: Registers decode as follows: enable at address 0x08, vector at 0x0C, pending status at 0x10, capability at 0x14. Any other address reads as 0, and writes to it change nothing.
- R2: Source bits are numbered as follows: evt_i[0] is bit 0 (data available), evt_i[1] is bit 1 (status valid), evt_i[2] is bit 2 (locality change) and evt_i[3] is bit 7 (command ready). A 0-to-1 change on a source input, seen at a clock edge, sets its pending bit at that edge. This happens whether or not the source is enabled.
- R3: A write to the status register clears exactly the pending bits that are 1 in the written value. All other pending bits keep their value.
- R4: If a source edge and a clear of the same bit happen at the same clock edge, the bit ends up set.
- R5: Only bits 0, 1, 2, 7 (per-source enables) and bit 31 (global enable) of the enable register can be written. Every other bit reads as 0.
- R6: The request is true only when the global enable is 1 and at least one pending bit has its enable bit set. While the request is false, the line stays at its idle level.
- R7: cfg_mode_i selects the line mode: 0 is an active-high level, 1 an active-low level, 2 a high pulse and 3 a low pulse. In the level modes the line is active exactly one cycle after the request is true, and idle otherwise.
- R8: In the pulse modes the line is active for exactly one cycle. That cycle comes one cycle after the request goes from false to true. No further pulse comes until the request has been false again.
- R9: The vector register keeps the low 8 bits of the last value written to it and reads back zero-extended.
- R10: The capability register reads bits 0, 1, 2 and 7 set (sources supported) and bits 3 to 6 set (all four line modes). Bit 8 equals parameter BURST_STATIC. Writes to this register have no effect.
- R11: After reset, the enable, vector and pending registers read 0 and the line sits at the idle level of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 4 | Event source inputs |
| cfg_mode_i | input | 2 | Line mode select |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench aims at a source edge and a write-1 clear of the same bit at the same clock edge. A design that let the clear win would lose that event, and the status read-back would show 0. Sources are kept pending while the global enable is off. A design that ignored the global bit would drive the line active. In the pulse modes the request is held high across many cycles. A design that re-armed on level instead of edge would emit repeated pulses, or hold the line active. Random writes to the capability and unmapped addresses, and the unwritable enable bits, expose decode errors that a design would show as stray read-back bits.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int SIC_NSRC = 4;

    localparam logic [7:0] OFS_ENABLE = 8'h08;
    localparam logic [7:0] OFS_VECTOR = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_CAPS   = 8'h14;

    typedef enum logic [1:0] {
        MODE_LVL_HI   = 2'd0,
        MODE_LVL_LO   = 2'd1,
        MODE_PULSE_HI = 2'd2,
        MODE_PULSE_LO = 2'd3
    } line_mode_e;

    typedef enum logic [1:0] {
        OS_QUIET = 2'd0,
        OS_PULSE = 2'd1,
        OS_HOLD  = 2'd2,
        OS_LEVEL = 2'd3
    } out_state_e;

    // Register bit that carries source idx
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/sic_src_capture.sv
module sic_src_capture #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic prev_r;
        logic pend_r;
        logic rise;

        assign rise      = src_i[g] & ~prev_r;
        assign pend_o[g] = pend_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_r <= 1'b0;
                pend_r <= 1'b0;
            end else begin
                prev_r <= src_i[g];
                // a new edge beats a simultaneous clear
                pend_r <= rise | (pend_r & ~clr_i[g]);
            end
        end

        assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (src_i[g] && !prev_r) |=> pend_o[g]);

        assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !(src_i[g] && !prev_r)) |=> !pend_o[g]);
    end
endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int   NSRC         = 4,
    parameter int   ADDR_W       = 8,
    parameter int   DATA_W       = 32,
    parameter logic BURST_STATIC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NSRC-1:0]   pend_i,
    output logic [NSRC-1:0]   src_en_o,
    output logic              glob_en_o,
    output logic [NSRC-1:0]   clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int GBIT  = DATA_W - 1;
    localparam int VEC_W = 8;

    logic [NSRC-1:0]  en_q;
    logic             glob_q;
    logic [VEC_W-1:0] vec_q;
    logic             hit_en, hit_vec, hit_st;
    logic [DATA_W-1:0] en_view, pend_view, caps_view;

    assign hit_en  = wr_i && (addr_i == ADDR_W'(OFS_ENABLE));
    assign hit_vec = wr_i && (addr_i == ADDR_W'(OFS_VECTOR));
    assign hit_st  = wr_i && (addr_i == ADDR_W'(OFS_STATUS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            glob_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            if (hit_en) begin
                for (int i = 0; i < NSRC; i++) en_q[i] <= wdata_i[src_pos(i)];
                glob_q <= wdata_i[GBIT];
            end
            if (hit_vec) vec_q <= wdata_i[VEC_W-1:0];
        end
    end

    always_comb begin
        en_view   = '0;
        pend_view = '0;
        caps_view = '0;
        clr_o     = '0;
        for (int i = 0; i < NSRC; i++) begin
            en_view[src_pos(i)]   = en_q[i];
            pend_view[src_pos(i)] = pend_i[i];
            caps_view[src_pos(i)] = 1'b1;
            clr_o[i]              = hit_st && wdata_i[src_pos(i)];
        end
        en_view[GBIT]  = glob_q;
        caps_view[6:3] = 4'hF;
        caps_view[8]   = BURST_STATIC;
    end

    always_comb begin
        case (addr_i)
            ADDR_W'(OFS_ENABLE): rdata_o = en_view;
            ADDR_W'(OFS_VECTOR): rdata_o = DATA_W'(vec_q);
            ADDR_W'(OFS_STATUS): rdata_o = pend_view;
            ADDR_W'(OFS_CAPS):   rdata_o = caps_view;
            default:             rdata_o = '0;
        endcase
    end

    assign src_en_o  = en_q;
    assign glob_en_o = glob_q;

    assert_vector_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec |=> vec_q == $past(wdata_i[VEC_W-1:0]));

    assert_global_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_en |=> glob_en_o == $past(wdata_i[GBIT]));
endmodule

// File: rtl/sic_line_fsm.sv
module sic_line_fsm
    import sic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  line_mode_e mode_i,
    output logic       line_o
);
    out_state_e st_q, st_d;
    logic       pulse_mode;
    logic       low_idle;
    logic       active;

    assign pulse_mode = (mode_i == MODE_PULSE_HI) || (mode_i == MODE_PULSE_LO);
    assign low_idle   = (mode_i == MODE_LVL_LO)   || (mode_i == MODE_PULSE_LO);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OS_QUIET: if (req_i) st_d = pulse_mode ? OS_PULSE : OS_LEVEL;
            OS_PULSE: st_d = req_i ? OS_HOLD : OS_QUIET;
            OS_HOLD: begin
                if (!req_i)          st_d = OS_QUIET;
                else if (!pulse_mode) st_d = OS_LEVEL;
            end
            OS_LEVEL: begin
                if (!req_i)          st_d = OS_QUIET;
                else if (pulse_mode) st_d = OS_HOLD;
            end
            default: st_d = OS_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OS_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        active = (st_q == OS_PULSE) || (st_q == OS_LEVEL);
        line_o = active ^ low_idle;
    end

    assert_idle_without_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !active);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OS_PULSE) |=> (st_q != OS_PULSE));
endmodule

// File: rtl/sic_irq_ctrl.sv
module sic_irq_ctrl
    import sic_pkg::*;
#(
    parameter int   ADDR_W       = 8,
    parameter int   DATA_W       = 32,
    parameter logic BURST_STATIC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        evt_i,
    input  logic [1:0]        cfg_mode_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int NSRC = SIC_NSRC;

    logic [NSRC-1:0] pend, src_en, clr;
    logic            glob_en;
    logic            req;

    sic_src_capture #(.NSRC(NSRC)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (evt_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    sic_regs #(
        .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_STATIC(BURST_STATIC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr_i),
        .wr_i      (reg_wr_i),
        .wdata_i   (reg_wdata_i),
        .pend_i    (pend),
        .src_en_o  (src_en),
        .glob_en_o (glob_en),
        .clr_o     (clr),
        .rdata_o   (reg_rdata_o)
    );

    assign req = glob_en && |(src_en & pend);

    sic_line_fsm u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req),
        .mode_i (line_mode_e'(cfg_mode_i)),
        .line_o (irq_o)
    );
endmodule

// File: tb/sic_irq_ctrl_tb.sv
module sic_irq_ctrl_tb_top;
    localparam time CLK_PERIOD = 10;
    localparam int  PHASE_CYCLES = 600;
    localparam logic [31:0] CAPS_EXP = 32'h0000_01FF;
    localparam logic [31:0] EN_MASK  = 32'h8000_0087;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt = '0;
    logic [1:0]  mode = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errs   = 0;

    logic [31:0] m_en, m_st;
    logic [7:0]  m_vec;
    logic [3:0]  m_prev;
    logic        r1, r2;

    always #(CLK_PERIOD/2) clk = ~clk;

    sic_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_mode_i(mode),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] ev_bits(input logic [3:0] e);
        return {24'd0, e[3], 4'd0, e[2:0]};
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h08:   return m_en;
            8'h0C:   return {24'd0, m_vec};
            8'h10:   return m_st;
            8'h14:   return CAPS_EXP;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'h08:   return "R5";
            8'h0C:   return "R9";
            8'h10:   return "R2/R3";
            8'h14:   return "R10";
            default: return "R1";
        endcase
    endfunction

    function automatic logic exp_line();
        logic act;
        act = mode[1] ? (r1 && !r2) : r1;
        return act ^ (mode == 2'd1 || mode == 2'd3);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock edge: update model with the inputs present at the edge, then check the line
    task automatic tick();
        logic req_now;
        logic [31:0] clr;
        @(posedge clk);
        req_now = m_en[31] && |(m_en[30:0] & m_st[30:0]);
        r2 = r1;
        r1 = req_now;
        clr = (wr && addr == 8'h10) ? wdata : 32'd0;
        m_st = (m_st & ~clr) | ev_bits(evt & ~m_prev);
        m_prev = evt;
        if (wr && addr == 8'h08) m_en = wdata & EN_MASK;
        if (wr && addr == 8'h0C) m_vec = wdata[7:0];
        #1;
        chk(mode[1] ? "R6/R8 line" : "R6/R7 line", {31'd0, irq}, {31'd0, exp_line()});
    endtask

    task automatic rd_check(input logic [7:0] a);
        addr = a;
        wr = 1'b0;
        #1;
        chk(read_tag(a), rdata, exp_read(a));
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic apply_reset(input logic [1:0] md);
        rst_n = 1'b0; evt = '0; wr = 1'b0; mode = md;
        repeat (3) @(posedge clk);
        #1;
        m_en = '0; m_st = '0; m_vec = '0; m_prev = '0; r1 = 1'b0; r2 = 1'b0;
        rst_n = 1'b1;
        chk("R11 idle line", {31'd0, irq}, {31'd0, (md == 2'd1 || md == 2'd3)});
        rd_check(8'h08);
        rd_check(8'h0C);
        rd_check(8'h10);
        chk("R11 status zero", rdata, 32'd0);
        rd_check(8'h14);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] addr_set [6];
        addr_set = '{8'h08, 8'h0C, 8'h10, 8'h14, 8'h00, 8'h18};
        void'($urandom(32'h5EED_1234));

        for (int md = 0; md < 4; md++) begin
            apply_reset(2'(md));

            if (md == 0) begin
                // R4: edge and clear of the same bit at one edge
                do_write(8'h08, 32'h8000_0087);
                evt = 4'b0001;
                do_write(8'h10, 32'h0000_0001);
                rd_check(8'h10);
                chk("R4 set wins", rdata & 32'h1, 32'h1);
                evt = 4'b0000;
                tick();
                // R6: global enable off with pending sources
                do_write(8'h08, 32'h0000_0087);
                evt = 4'b1000;
                repeat (3) tick();
                chk("R6 global off idle", {31'd0, irq}, 32'd0);
                evt = 4'b0000;
                // R10: capability ignores writes
                do_write(8'h14, 32'h0);
                rd_check(8'h14);
                // R9: vector keeps low byte
                do_write(8'h0C, 32'h0000_01A5);
                rd_check(8'h0C);
                chk("R9 vector", rdata, 32'h0000_00A5);
                // R1: unmapped write changes nothing
                do_write(8'h04, 32'hFFFF_FFFF);
                rd_check(8'h04);
                rd_check(8'h08);
                do_write(8'h10, 32'hFFFF_FFFF);
            end

            if (md >= 2) begin
                // R8: long request gives one pulse only
                do_write(8'h08, 32'h8000_0001);
                evt = 4'b0001;
                repeat (6) tick();
                evt = 4'b0000;
                do_write(8'h10, 32'h1);
                repeat (2) tick();
            end

            for (int c = 0; c < PHASE_CYCLES; c++) begin
                logic [31:0] r;
                tick();
                rd_check(addr_set[$urandom % 6]);
                evt = evt ^ (4'($urandom) & 4'($urandom));
                r = $urandom;
                if (r[2:0] == 3'd0) begin
                    addr = addr_set[$urandom % 6];
                    wdata = $urandom;
                    if (addr == 8'h08 && r[4:3] != 2'd0) wdata[31] = 1'b1;
                    wr = 1'b1;
                end else begin
                    wr = 1'b0;
                end
            end
            wr = 1'b0;
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule